// File: doc/BRIEF.md
# Coherence Directory Entry Controller for an Inclusive Shared L2

This block keeps the coherence record attached to one block of a shared, inclusive L2 cache in a chip with `NCORE` cores, each with a private L1. The L2 tag pipeline reads the directory entry for a block and presents it together with a request. The request is an L1 read miss, an L1 write miss, a dirty-sector writeback from an L1 owner, or an L2 eviction of the block. The controller works out the new entry and any invalidations or owner interventions that the request needs. When the remote side has answered, it hands the entry back for writing. One L2 block covers `NSECT` L1-sized sectors.

An entry is two state bits over an `NCORE`-bit field. In the shared state the field is a presence vector. In the L1-modified state the same bits hold the owning core and the number of dirty sectors it has, so no extra storage is needed. Each dirty-sector writeback lowers the count. The last one drops the block back to shared with the owner as its only sharer, so later readers are served from L2 without an intervention. L1 caches drop clean lines silently, so a presence vector may name cores that no longer hold the block. Invalidation acknowledgements from any core, targeted or not, are accepted and simply absorbed.

The controller handles one transaction at a time. Its FSM has three states. `FS_IDLE` accepts a request. `FS_WAIT_ACK` waits for the acknowledgements of the invalidations it sent. `FS_WAIT_IVN` waits for the owner's intervention response. The transitions are: IDLE→IDLE for a request that needs no remote action; IDLE→WAIT_ACK when invalidations go out; IDLE→WAIT_IVN when an intervention goes out; WAIT_ACK→IDLE on the acknowledgement that clears the last targeted core; WAIT_IVN→IDLE on `ivn_done`.

Top module: `l2dir_ctrl`

## Requirements
- R1: After reset `req_ready` is 1 and `inv_valid`, `ivn_valid` and `dir_wr_valid` are 0.
- R2: An entry is `{state[1:0], field[NCORE-1:0]}`. The state codes are 00 invalid, 01 shared and 10 L1-modified. In the shared state, field bit i marks core i. In the modified state, field[2:0] holds the owner, field[4:3] holds the dirty-sector count minus one, and the higher field bits are zero (default parameters).
- R3: A read miss to an invalid or shared block gives `dir_wr_valid` in the cycle after acceptance. The written entry is shared, with the requester's bit added. No invalidation or intervention is issued.
- R4: A read miss by a non-owner to a modified block issues one intervention to the owner, with `ivn_excl`=0. After `ivn_done` the entry is written as shared, holding exactly the owner and the requester.
- R5: A write miss to a shared block sends invalidations to every sharer except the requester. Once all are acknowledged, it writes a modified entry with the requester as owner and one dirty sector. If no other sharer exists, the entry is written in the cycle after acceptance.
- R6: Acknowledgements from cores that were not targeted, or that arrive while idle, are accepted and have no effect. Completion happens on the cycle that clears the last targeted core.
- R7: A write miss by the owner of a modified block raises the dirty count by one, saturating at `NSECT`, and issues no traffic. A write miss by another core sends an exclusive intervention (`ivn_excl`=1) to the owner, then writes the requester as owner with one dirty sector.
- R8: A writeback from the owner lowers the dirty count by one. The writeback of the last dirty sector writes a shared entry holding only the owner, and a later read miss to that entry causes no intervention.
- R9: A writeback from a core that is not the owner, or to a block that is not modified, writes the entry back unchanged.
- R10: An L2 eviction invalidates every sharer of a shared block, or sends an exclusive intervention to the owner of a modified block. After the response it writes an all-zero invalid entry. Evicting an invalid block writes it at once.
- R11: `req_ready` is 0 while invalidations or an intervention are outstanding, and a request presented then is not taken.
- R12: `inv_valid`, `ivn_valid` and `dir_wr_valid` are never high together. `inv_valid` and `ivn_valid` are single-cycle pulses issued in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; request taken when both are high |
| req_op | input | 2 | 00 read miss, 01 write miss, 10 dirty-sector writeback, 11 L2 eviction |
| req_core | input | log2(NCORE) | Requesting core |
| dir_rd_entry | input | NCORE+2 | Current directory entry read alongside the L2 tag |
| ack_vec | input | NCORE | Invalidation acknowledgements, one bit per core |
| ivn_done | input | 1 | Owner has answered the intervention |
| inv_valid | output | 1 | Invalidation burst issued |
| inv_vec | output | NCORE | Cores to invalidate |
| ivn_valid | output | 1 | Intervention issued |
| ivn_core | output | log2(NCORE) | Core receiving the intervention |
| ivn_excl | output | 1 | 1: owner must also drop its copy |
| dir_wr_valid | output | 1 | Updated entry ready to be written |
| dir_wr_entry | output | NCORE+2 | Updated directory entry |

## Verification
The closest collision is in `FS_WAIT_ACK`. There, the acknowledgement that clears the last targeted core can arrive in the same cycle as acknowledgements from cores that were never targeted, such as stale sharers or idle cores. The bench provokes this by sending such mixed acknowledgement vectors. It also sends a partial vector that includes a spurious bit. It judges the result by whether the entry write appears exactly on the cycle after the last real acknowledgement, and not before it. A second overlap is a new request presented while the controller is busy. The bench checks that the request leaves no trace once the transaction ends.

// File: rtl/l2dir_pkg.sv
package l2dir_pkg;

    typedef enum logic [1:0] {
        DST_INV = 2'b00,
        DST_SHR = 2'b01,
        DST_MOD = 2'b10
    } dstate_t;

    typedef enum logic [1:0] {
        ROP_READ  = 2'b00,
        ROP_WRITE = 2'b01,
        ROP_WBACK = 2'b10,
        ROP_EVICT = 2'b11
    } rop_t;

    typedef enum logic [1:0] {
        FS_IDLE     = 2'b00,
        FS_WAIT_ACK = 2'b01,
        FS_WAIT_IVN = 2'b10
    } fsm_t;

endpackage

// File: rtl/l2dir_decode.sv
module l2dir_decode #(
    parameter int NCORE = 8,
    parameter int NSECT = 4
) (
    input  logic [NCORE+1:0]             entry,
    output logic [1:0]                   st,
    output logic [NCORE-1:0]             vec,
    output logic [$clog2(NCORE)-1:0]     owner,
    output logic [$clog2(NSECT)-1:0]     dcnt
);
    localparam int IDW = $clog2(NCORE);
    localparam int CNW = $clog2(NSECT);

    // Owner and dirty count reuse the low bits of the presence vector.
    always_comb begin
        st    = entry[NCORE+1:NCORE];
        vec   = entry[NCORE-1:0];
        owner = entry[IDW-1:0];
        dcnt  = entry[IDW+CNW-1:IDW];
    end
endmodule

// File: rtl/l2dir_policy.sv
module l2dir_policy
    import l2dir_pkg::*;
#(
    parameter int NCORE = 8,
    parameter int NSECT = 4
) (
    input  logic [1:0]                   op,
    input  logic [$clog2(NCORE)-1:0]     core,
    input  logic [1:0]                   st,
    input  logic [NCORE-1:0]             vec,
    input  logic [$clog2(NCORE)-1:0]     owner,
    input  logic [$clog2(NSECT)-1:0]     dcnt,
    output logic [NCORE+1:0]             nxt_entry,
    output logic [NCORE-1:0]             inv_mask,
    output logic                         need_ivn,
    output logic                         ivn_excl
);
    localparam int IDW = $clog2(NCORE);
    localparam int CNW = $clog2(NSECT);
    localparam int EW  = NCORE + 2;
    localparam logic [CNW-1:0] CNT_MAX = CNW'(NSECT - 1);

    function automatic logic [EW-1:0] pack_mod(input logic [IDW-1:0] o,
                                               input logic [CNW-1:0] c);
        logic [NCORE-1:0] f;
        f = '0;
        f[IDW-1:0]       = o;
        f[IDW+CNW-1:IDW] = c;
        return {DST_MOD, f};
    endfunction

    logic [NCORE-1:0] reqbit;
    logic [NCORE-1:0] ownbit;
    logic             is_owner;

    always_comb begin
        reqbit        = '0;
        reqbit[core]  = 1'b1;
        ownbit        = '0;
        ownbit[owner] = 1'b1;
        is_owner      = (owner == core);
    end

    always_comb begin
        nxt_entry = {st, vec};
        inv_mask  = '0;
        need_ivn  = 1'b0;
        ivn_excl  = 1'b0;
        unique case (rop_t'(op))
            ROP_READ: begin
                unique case (st)
                    DST_SHR: nxt_entry = {DST_SHR, vec | reqbit};
                    DST_MOD: begin
                        if (!is_owner) begin
                            need_ivn  = 1'b1;
                            nxt_entry = {DST_SHR, ownbit | reqbit};
                        end
                    end
                    default: nxt_entry = {DST_SHR, reqbit};
                endcase
            end
            ROP_WRITE: begin
                unique case (st)
                    DST_SHR: begin
                        inv_mask  = vec & ~reqbit;
                        nxt_entry = pack_mod(core, '0);
                    end
                    DST_MOD: begin
                        if (is_owner) begin
                            nxt_entry = pack_mod(core, (dcnt == CNT_MAX) ? dcnt : dcnt + 1'b1);
                        end else begin
                            need_ivn  = 1'b1;
                            ivn_excl  = 1'b1;
                            nxt_entry = pack_mod(core, '0);
                        end
                    end
                    default: nxt_entry = pack_mod(core, '0);
                endcase
            end
            ROP_WBACK: begin
                if (st == DST_MOD && is_owner) begin
                    if (dcnt == '0) nxt_entry = {DST_SHR, reqbit};
                    else            nxt_entry = pack_mod(core, dcnt - 1'b1);
                end
            end
            ROP_EVICT: begin
                nxt_entry = '0;
                unique case (st)
                    DST_SHR: inv_mask = vec;
                    DST_MOD: begin
                        need_ivn = 1'b1;
                        ivn_excl = 1'b1;
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/l2dir_ack_track.sv
module l2dir_ack_track #(
    parameter int NCORE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NCORE-1:0] load_mask,
    input  logic [NCORE-1:0] ack_vec,
    output logic             all_clear
);
    logic [NCORE-1:0] pending;

    // Bits for cores that were never targeted simply fall away.
    always_comb all_clear = ((pending & ~ack_vec) == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pending <= '0;
        else if (load) pending <= load_mask;
        else           pending <= pending & ~ack_vec;
    end
endmodule

// File: rtl/l2dir_ctrl.sv
module l2dir_ctrl
    import l2dir_pkg::*;
#(
    parameter int NCORE = 8,
    parameter int NSECT = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [1:0]                   req_op,
    input  logic [$clog2(NCORE)-1:0]     req_core,
    input  logic [NCORE+1:0]             dir_rd_entry,
    input  logic [NCORE-1:0]             ack_vec,
    input  logic                         ivn_done,
    output logic                         inv_valid,
    output logic [NCORE-1:0]             inv_vec,
    output logic                         ivn_valid,
    output logic [$clog2(NCORE)-1:0]     ivn_core,
    output logic                         ivn_excl,
    output logic                         dir_wr_valid,
    output logic [NCORE+1:0]             dir_wr_entry
);
    localparam int IDW = $clog2(NCORE);
    localparam int CNW = $clog2(NSECT);
    localparam int EW  = NCORE + 2;

    fsm_t             fs, fs_nxt;
    logic             accept;
    logic [1:0]       cur_st;
    logic [NCORE-1:0] cur_vec;
    logic [IDW-1:0]   cur_owner;
    logic [CNW-1:0]   cur_dcnt;
    logic [EW-1:0]    pol_entry;
    logic [NCORE-1:0] pol_inv;
    logic             pol_ivn;
    logic             pol_excl;
    logic             acks_done;
    logic [EW-1:0]    hold_entry;

    l2dir_decode #(.NCORE(NCORE), .NSECT(NSECT)) u_decode (
        .entry (dir_rd_entry),
        .st    (cur_st),
        .vec   (cur_vec),
        .owner (cur_owner),
        .dcnt  (cur_dcnt)
    );

    l2dir_policy #(.NCORE(NCORE), .NSECT(NSECT)) u_policy (
        .op        (req_op),
        .core      (req_core),
        .st        (cur_st),
        .vec       (cur_vec),
        .owner     (cur_owner),
        .dcnt      (cur_dcnt),
        .nxt_entry (pol_entry),
        .inv_mask  (pol_inv),
        .need_ivn  (pol_ivn),
        .ivn_excl  (pol_excl)
    );

    l2dir_ack_track #(.NCORE(NCORE)) u_acks (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_mask (pol_inv),
        .ack_vec   (ack_vec),
        .all_clear (acks_done)
    );

    always_comb begin
        req_ready = (fs == FS_IDLE);
        accept    = req_valid && req_ready;
    end

    always_comb begin
        fs_nxt = fs;
        unique case (fs)
            FS_IDLE: begin
                if (accept) begin
                    if (pol_inv != '0) fs_nxt = FS_WAIT_ACK;
                    else if (pol_ivn)  fs_nxt = FS_WAIT_IVN;
                end
            end
            FS_WAIT_ACK: if (acks_done) fs_nxt = FS_IDLE;
            FS_WAIT_IVN: if (ivn_done)  fs_nxt = FS_IDLE;
            default:     fs_nxt = FS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs <= FS_IDLE;
        else        fs <= fs_nxt;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inv_valid    <= 1'b0;
            inv_vec      <= '0;
            ivn_valid    <= 1'b0;
            ivn_core     <= '0;
            ivn_excl     <= 1'b0;
            dir_wr_valid <= 1'b0;
            dir_wr_entry <= '0;
            hold_entry   <= '0;
        end else begin
            inv_valid    <= 1'b0;
            ivn_valid    <= 1'b0;
            dir_wr_valid <= 1'b0;
            unique case (fs)
                FS_IDLE: begin
                    if (accept) begin
                        hold_entry <= pol_entry;
                        if (pol_inv != '0) begin
                            inv_valid <= 1'b1;
                            inv_vec   <= pol_inv;
                        end else if (pol_ivn) begin
                            ivn_valid <= 1'b1;
                            ivn_core  <= cur_owner;
                            ivn_excl  <= pol_excl;
                        end else begin
                            dir_wr_valid <= 1'b1;
                            dir_wr_entry <= pol_entry;
                        end
                    end
                end
                FS_WAIT_ACK: begin
                    if (acks_done) begin
                        dir_wr_valid <= 1'b1;
                        dir_wr_entry <= hold_entry;
                    end
                end
                FS_WAIT_IVN: begin
                    if (ivn_done) begin
                        dir_wr_valid <= 1'b1;
                        dir_wr_entry <= hold_entry;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/l2dir_ctrl_chk.sv
module l2dir_ctrl_chk #(
    parameter int NCORE = 8,
    parameter int NSECT = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_ready,
    input logic [1:0]               req_op,
    input logic [$clog2(NCORE)-1:0] req_core,
    input logic                     inv_valid,
    input logic [NCORE-1:0]         inv_vec,
    input logic                     ivn_valid,
    input logic                     ivn_excl,
    input logic                     dir_wr_valid,
    input logic [NCORE+1:0]         dir_wr_entry
);
    localparam int IDW = $clog2(NCORE);
    localparam int CNW = $clog2(NSECT);

    a_r12_one_output_kind: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({inv_valid, ivn_valid, dir_wr_valid}));

    a_r12_inv_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |=> !inv_valid);

    a_r12_ivn_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ivn_valid |=> !ivn_valid);

    a_r11_busy_while_remote: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid || ivn_valid) |-> !req_ready);

    a_r3_idle_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr_valid |-> req_ready);

    a_r5_no_self_invalidate: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && $past(req_op) == 2'b01) |-> (inv_vec[$past(req_core)] == 1'b0));

    a_r5_inv_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (inv_vec != '0));

    a_r4_read_ivn_shared: assert property (@(posedge clk) disable iff (!rst_n)
        (ivn_valid && $past(req_op) == 2'b00) |-> !ivn_excl);

    a_r2_mod_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_wr_valid && dir_wr_entry[NCORE+1:NCORE] == 2'b10)
            |-> ((dir_wr_entry[NCORE-1:0] >> (IDW + CNW)) == '0));
endmodule

bind l2dir_ctrl l2dir_ctrl_chk #(.NCORE(NCORE), .NSECT(NSECT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .req_op       (req_op),
    .req_core     (req_core),
    .inv_valid    (inv_valid),
    .inv_vec      (inv_vec),
    .ivn_valid    (ivn_valid),
    .ivn_excl     (ivn_excl),
    .dir_wr_valid (dir_wr_valid),
    .dir_wr_entry (dir_wr_entry)
);

// File: tb/l2dir_ctrl_bench.sv
`timescale 1ns/1ps
module l2dir_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_op = 2'b00;
    logic [2:0] req_core = 3'd0;
    logic [9:0] dir_rd_entry = '0;
    logic [7:0] ack_vec = '0;
    logic       ivn_done = 1'b0;
    logic       inv_valid;
    logic [7:0] inv_vec;
    logic       ivn_valid;
    logic [2:0] ivn_core;
    logic       ivn_excl;
    logic       dir_wr_valid;
    logic [9:0] dir_wr_entry;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    l2dir_ctrl #(.NCORE(8), .NSECT(4)) u_l2dir_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_core(req_core), .dir_rd_entry(dir_rd_entry),
        .ack_vec(ack_vec), .ivn_done(ivn_done), .inv_valid(inv_valid),
        .inv_vec(inv_vec), .ivn_valid(ivn_valid), .ivn_core(ivn_core),
        .ivn_excl(ivn_excl), .dir_wr_valid(dir_wr_valid), .dir_wr_entry(dir_wr_entry)
    );

    localparam logic [1:0] OP_RD = 2'b00, OP_WR = 2'b01, OP_WB = 2'b10, OP_EV = 2'b11;

    function automatic logic [9:0] e_shr(input logic [7:0] v);
        return {2'b01, v};
    endfunction

    function automatic logic [9:0] e_mod(input logic [2:0] o, input logic [2:0] dirty);
        logic [9:0] e;
        logic [2:0] dm;
        dm = dirty - 3'd1;
        e = '0;
        e[9:8] = 2'b10;
        e[2:0] = o;
        e[4:3] = dm[1:0];
        return e;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [2:0] core, input logic [9:0] ent);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_core = core; dir_rd_entry = ent;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_ack(input logic [7:0] v);
        ack_vec = v;
        @(negedge clk);
        ack_vec = '0;
    endtask

    task automatic send_done();
        ivn_done = 1'b1;
        @(negedge clk);
        ivn_done = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 ready", 32'(req_ready), 1);
        check("R1 inv", 32'(inv_valid), 0);
        check("R1 ivn", 32'(ivn_valid), 0);
        check("R1 wr", 32'(dir_wr_valid), 0);
    endtask

    task automatic t_read_fill();
        issue(OP_RD, 3'd2, 10'h000);
        check("R3 wr", 32'(dir_wr_valid), 1);
        check("R3 R2 entry", 32'(dir_wr_entry), 32'(e_shr(8'h04)));
        check("R3 no inv", 32'(inv_valid), 0);
        issue(OP_RD, 3'd5, e_shr(8'h04));
        check("R3 add sharer", 32'(dir_wr_entry), 32'(e_shr(8'h24)));
        check("R3 no ivn", 32'(ivn_valid), 0);
    endtask

    task automatic t_write_shared();
        issue(OP_WR, 3'd1, e_shr(8'h86));
        check("R5 inv", 32'(inv_valid), 1);
        check("R5 inv vec", 32'(inv_vec), 32'h84);
        check("R11 busy", 32'(req_ready), 0);
        req_valid = 1'b1; req_op = OP_RD; req_core = 3'd0; dir_rd_entry = '0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R12 inv pulse", 32'(inv_valid), 0);
        check("R11 still busy", 32'(req_ready), 0);
        send_ack(8'h14);
        check("R6 partial", 32'(dir_wr_valid), 0);
        check("R6 wait", 32'(req_ready), 0);
        send_ack(8'h81);
        check("R6 complete", 32'(dir_wr_valid), 1);
        check("R5 new owner", 32'(dir_wr_entry), 32'(e_mod(3'd1, 3'd1)));
        @(negedge clk);
        check("R11 busy req dropped", 32'(dir_wr_valid), 0);
        check("R11 ready again", 32'(req_ready), 1);
    endtask

    task automatic t_write_alone();
        issue(OP_WR, 3'd3, e_shr(8'h08));
        check("R5 alone inv", 32'(inv_valid), 0);
        check("R5 alone wr", 32'(dir_wr_valid), 1);
        check("R5 alone entry", 32'(dir_wr_entry), 32'(e_mod(3'd3, 3'd1)));
    endtask

    task automatic t_read_mod();
        issue(OP_RD, 3'd6, e_mod(3'd3, 3'd2));
        check("R4 ivn", 32'(ivn_valid), 1);
        check("R4 ivn core", 32'(ivn_core), 3);
        check("R4 ivn shared", 32'(ivn_excl), 0);
        @(negedge clk);
        @(negedge clk);
        check("R4 waits", 32'(dir_wr_valid), 0);
        send_done();
        check("R4 wr", 32'(dir_wr_valid), 1);
        check("R4 entry", 32'(dir_wr_entry), 32'(e_shr(8'h48)));
    endtask

    task automatic t_write_mod();
        issue(OP_WR, 3'd0, e_mod(3'd5, 3'd3));
        check("R7 ivn", 32'(ivn_valid), 1);
        check("R7 ivn core", 32'(ivn_core), 5);
        check("R7 ivn excl", 32'(ivn_excl), 1);
        send_done();
        check("R7 new owner", 32'(dir_wr_entry), 32'(e_mod(3'd0, 3'd1)));
        issue(OP_WR, 3'd4, e_mod(3'd4, 3'd2));
        check("R7 owner inc", 32'(dir_wr_entry), 32'(e_mod(3'd4, 3'd3)));
        check("R7 no traffic", 32'(ivn_valid), 0);
        issue(OP_WR, 3'd4, e_mod(3'd4, 3'd4));
        check("R7 saturate", 32'(dir_wr_entry), 32'(e_mod(3'd4, 3'd4)));
    endtask

    task automatic t_writeback();
        issue(OP_WB, 3'd4, e_mod(3'd4, 3'd3));
        check("R8 dec", 32'(dir_wr_entry), 32'(e_mod(3'd4, 3'd2)));
        issue(OP_WB, 3'd4, e_mod(3'd4, 3'd1));
        check("R8 last", 32'(dir_wr_entry), 32'(e_shr(8'h10)));
        issue(OP_RD, 3'd6, e_shr(8'h10));
        check("R8 no ivn", 32'(ivn_valid), 0);
        check("R8 read", 32'(dir_wr_entry), 32'(e_shr(8'h50)));
    endtask

    task automatic t_stale_wb();
        issue(OP_WB, 3'd2, e_mod(3'd4, 3'd2));
        check("R9 non-owner", 32'(dir_wr_entry), 32'(e_mod(3'd4, 3'd2)));
        check("R9 no ivn", 32'(ivn_valid), 0);
        issue(OP_WB, 3'd1, e_shr(8'h02));
        check("R9 shared", 32'(dir_wr_entry), 32'(e_shr(8'h02)));
    endtask

    task automatic t_evict();
        issue(OP_EV, 3'd0, e_shr(8'h21));
        check("R10 inv vec", 32'(inv_vec), 32'h21);
        send_ack(8'h21);
        check("R10 shr wr", 32'(dir_wr_valid), 1);
        check("R10 shr entry", 32'(dir_wr_entry), 0);
        issue(OP_EV, 3'd0, e_mod(3'd2, 3'd1));
        check("R10 ivn core", 32'(ivn_core), 2);
        check("R10 ivn excl", 32'(ivn_excl), 1);
        send_done();
        check("R10 mod entry", 32'(dir_wr_entry), 0);
        issue(OP_EV, 3'd0, 10'h000);
        check("R10 inv direct", 32'(dir_wr_valid), 1);
    endtask

    task automatic t_idle_acks();
        send_ack(8'hFF);
        check("R6 idle ack wr", 32'(dir_wr_valid), 0);
        check("R6 idle ack inv", 32'(inv_valid), 0);
        check("R6 idle ready", 32'(req_ready), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_fill();
        t_write_shared();
        t_write_alone();
        t_read_mod();
        t_write_mod();
        t_writeback();
        t_stale_wb();
        t_evict();
        t_idle_acks();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule